// File: doc/BRIEF.md
# Masked Interrupt Event Controller

This block collects thirteen interrupt-worthy events from the surrounding network controller logic into one 32-bit event register, gates them with a 32-bit mask register, and drives thirteen separate interrupt lines. Neighbouring logic raises an event with a one-cycle pulse. Software sees pending events by reading the event register and acknowledges them by writing ones to it. It selects which events reach the interrupt lines through the mask register.

Two events come from register writes made elsewhere in the controller. Any write to the management frame register raises the management-complete event. A write to the transmit control register with bit 0 set raises the graceful-stop-complete event. Both registers are reached over a small register bus: word address, write enable, write data, and registered read data.

Top module: `irq_event_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the event register, the mask register, every interrupt line and the read data.
- R2: A one-cycle pulse on `evt_set[k]` sets event register bit 19+k. The events by bit are: 19 underrun, 20 retry limit, 21 late collision, 22 bus error, 23 management complete, 24 receive buffer, 25 receive frame, 26 transmit buffer, 27 transmit frame, 28 graceful stop, 29 babbling transmit, 30 babbling receive, 31 heartbeat.
- R3: A bus write to the event register at word address 1 clears every event bit where the write data is 1 and leaves the other bits unchanged.
- R4: The mask register at word address 2 is a plain 32-bit read/write register.
- R5: Event register bits 18 down to 0 always read as zero.
- R6: Interrupt line i is event AND mask of one bit, in this fixed order for lines 0 to 12: bits 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30.
- R7: Interrupt lines are registered. A line changes one clock after the event or mask bit it follows changes.
- R8: A pulse on `mgmt_wr` sets event bit 23.
- R9: A pulse on `tx_ctrl_wr` sets event bit 28 when `tx_ctrl_stop` is 1. It has no effect when `tx_ctrl_stop` is 0.
- R10: When a set pulse and a software clear hit the same event bit in the same cycle, the set wins and the bit stays 1.
- R11: Read data is registered. `bus_rdata` shows the register addressed in the previous cycle, as it was before that edge. Word addresses other than 1 and 2 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_set | input | 13 | One-cycle event set pulses; bit k sets event bit 19+k |
| mgmt_wr | input | 1 | Management frame register was written |
| tx_ctrl_wr | input | 1 | Transmit control register was written |
| tx_ctrl_stop | input | 1 | Bit 0 of the transmit control write |
| irq | output | 13 | Registered interrupt lines |

## Verification
The hardest case to reach from the ports is a set pulse and a software clear landing on the same event bit on the same clock edge. The bench drives the pulse and the bus write in the same low clock phase so that both are sampled together, then reads the bit back. A second difficulty is the permuted line order. A table of set and mask patterns isolates single lines, including lines whose source bit is masked while a neighbouring bit is open, so that a swapped mapping cannot go unnoticed. The one-cycle lag of the lines is checked at both edges: just before the change and just after it.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int REG_W   = 32;
  localparam int EVT_LSB = 19;
  localparam int NUM_EVT = 13;
  localparam int NUM_IRQ = 13;

  localparam int BIT_UNDERRUN = 19;
  localparam int BIT_RETRY    = 20;
  localparam int BIT_LATECOL  = 21;
  localparam int BIT_BUSERR   = 22;
  localparam int BIT_MGMT     = 23;
  localparam int BIT_RXBUF    = 24;
  localparam int BIT_RXFRM    = 25;
  localparam int BIT_TXBUF    = 26;
  localparam int BIT_TXFRM    = 27;
  localparam int BIT_GSTOP    = 28;
  localparam int BIT_BABTX    = 29;
  localparam int BIT_BABRX    = 30;
  localparam int BIT_HBEAT    = 31;

  // Source event bit for each interrupt line (fixed order)
  function automatic int line_src_bit(input int line);
    case (line)
      0:       return BIT_TXFRM;
      1:       return BIT_TXBUF;
      2:       return BIT_UNDERRUN;
      3:       return BIT_RETRY;
      4:       return BIT_RXFRM;
      5:       return BIT_RXBUF;
      6:       return BIT_MGMT;
      7:       return BIT_LATECOL;
      8:       return BIT_HBEAT;
      9:       return BIT_GSTOP;
      10:      return BIT_BUSERR;
      11:      return BIT_BABTX;
      default: return BIT_BABRX;
    endcase
  endfunction
endpackage

// File: rtl/irq_evt_regs.sv
module irq_evt_regs #(
  parameter int DATA_W    = irq_evt_pkg::REG_W,
  parameter int ADDR_W    = 4,
  parameter int EVT_LSB   = irq_evt_pkg::EVT_LSB,
  parameter int NUM_EVT   = irq_evt_pkg::NUM_EVT,
  parameter logic [ADDR_W-1:0] EVT_ADDR  = 1,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 2,
  parameter int MGMT_BIT  = irq_evt_pkg::BIT_MGMT,
  parameter int GSTOP_BIT = irq_evt_pkg::BIT_GSTOP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_EVT-1:0] set_vec,
  input  logic              mgmt_wr,
  input  logic              tx_ctrl_wr,
  input  logic              tx_ctrl_stop,
  output logic [DATA_W-1:0] evt_q,
  output logic [DATA_W-1:0] mask_q
);
  localparam int MGMT_IDX  = MGMT_BIT - EVT_LSB;
  localparam int GSTOP_IDX = GSTOP_BIT - EVT_LSB;

  logic [NUM_EVT-1:0] evt_bits;
  logic [NUM_EVT-1:0] set_all;
  logic [NUM_EVT-1:0] clr_all;
  logic               evt_wr;
  logic               mask_wr;

  assign evt_wr  = we && (addr == EVT_ADDR);
  assign mask_wr = we && (addr == MASK_ADDR);
  assign clr_all = evt_wr ? wdata[EVT_LSB +: NUM_EVT] : '0;

  always_comb begin
    set_all = set_vec;
    if (mgmt_wr)
      set_all[MGMT_IDX] = 1'b1;
    if (tx_ctrl_wr && tx_ctrl_stop)
      set_all[GSTOP_IDX] = 1'b1;
  end

  // Per-bit storage: a set beats a clear in the same cycle
  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    always_ff @(posedge clk) begin
      if (rst)
        evt_bits[k] <= 1'b0;
      else if (set_all[k])
        evt_bits[k] <= 1'b1;
      else if (clr_all[k])
        evt_bits[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (mask_wr)
      mask_q <= wdata;
  end

  assign evt_q = {evt_bits, {EVT_LSB{1'b0}}};
endmodule

// File: rtl/irq_evt_router.sv
module irq_evt_router #(
  parameter int DATA_W  = irq_evt_pkg::REG_W,
  parameter int NUM_IRQ = irq_evt_pkg::NUM_IRQ
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  evt_q,
  input  logic [DATA_W-1:0]  mask_q,
  output logic [NUM_IRQ-1:0] irq_q
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    localparam int SRC = irq_evt_pkg::line_src_bit(i);
    always_ff @(posedge clk) begin
      if (rst)
        irq_q[i] <= 1'b0;
      else
        irq_q[i] <= evt_q[SRC] & mask_q[SRC];
    end
  end
endmodule

// File: rtl/irq_evt_rdmux.sv
module irq_evt_rdmux #(
  parameter int DATA_W = irq_evt_pkg::REG_W,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] EVT_ADDR  = 1,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] evt_q,
  input  logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    case (addr)
      EVT_ADDR:  rd_next = evt_q;
      MASK_ADDR: rd_next = mask_q;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else
      rdata_q <= rd_next;
  end
endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl #(
  parameter int DATA_W  = irq_evt_pkg::REG_W,
  parameter int ADDR_W  = 4,
  parameter int NUM_EVT = irq_evt_pkg::NUM_EVT,
  parameter int NUM_IRQ = irq_evt_pkg::NUM_IRQ,
  parameter logic [ADDR_W-1:0] EVT_ADDR  = 1,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_EVT-1:0] evt_set,
  input  logic               mgmt_wr,
  input  logic               tx_ctrl_wr,
  input  logic               tx_ctrl_stop,
  output logic [NUM_IRQ-1:0] irq
);
  logic [DATA_W-1:0] evt_q;
  logic [DATA_W-1:0] mask_q;

  irq_evt_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT),
    .EVT_ADDR(EVT_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .set_vec(evt_set), .mgmt_wr(mgmt_wr), .tx_ctrl_wr(tx_ctrl_wr),
    .tx_ctrl_stop(tx_ctrl_stop), .evt_q(evt_q), .mask_q(mask_q)
  );

  irq_evt_router #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_router (
    .clk(clk), .rst(rst), .evt_q(evt_q), .mask_q(mask_q), .irq_q(irq)
  );

  irq_evt_rdmux #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EVT_ADDR(EVT_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_rdmux (
    .clk(clk), .rst(rst), .addr(bus_addr), .evt_q(evt_q), .mask_q(mask_q),
    .rdata_q(bus_rdata)
  );
endmodule

// File: rtl/irq_event_ctrl_chk.sv
module irq_event_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic [12:0] evt_set,
  input logic        mgmt_wr,
  input logic        tx_ctrl_wr,
  input logic [31:0] evt_q,
  input logic [31:0] mask_q,
  input logic [12:0] irq
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (evt_q == 32'h0 && mask_q == 32'h0 && irq == 13'h0));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((evt_q[31:19] & $past(evt_set)) == $past(evt_set)));

  // R3
  clear_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 4'd1 && evt_set == 13'h0 && !mgmt_wr && !tx_ctrl_wr)
      |=> ((evt_q & $past(bus_wdata)) == 32'h0));

  // R4
  mask_store_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 4'd2) |=> (mask_q == $past(bus_wdata)));

  // R5
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    evt_q[18:0] == 19'h0);

  // R7
  irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((|irq) == $past(|(evt_q & mask_q))));

  // R6
  heartbeat_line_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq[8] == $past(evt_q[31] & mask_q[31])));

  // R8
  mgmt_sets_chk: assert property (@(posedge clk) disable iff (rst)
    mgmt_wr |=> evt_q[23]);
endmodule

bind irq_event_ctrl irq_event_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .evt_set(evt_set), .mgmt_wr(mgmt_wr),
  .tx_ctrl_wr(tx_ctrl_wr), .evt_q(evt_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/irq_event_ctrl_bench.sv
module irq_event_ctrl_bench;
  localparam logic [3:0] A_EVT  = 4'd1;
  localparam logic [3:0] A_MASK = 4'd2;
  localparam int NVEC = 9;
  // {set pulses[12:0], mask[31:0], expected irq[12:0]}
  localparam logic [57:0] VEC [NVEC] = '{
    {13'h0100, 32'hFFFF_FFFF, 13'h0001},
    {13'h0001, 32'hFFFF_FFFF, 13'h0004},
    {13'h1000, 32'hFFFF_FFFF, 13'h0100},
    {13'h1FFF, 32'h0000_0000, 13'h0000},
    {13'h1FFF, 32'h8000_0000, 13'h0100},
    {13'h0800, 32'hFFFF_FFFF, 13'h1000},
    {13'h0008, 32'h0040_0000, 13'h0400},
    {13'h1FFF, 32'h0810_0000, 13'h0009},
    {13'h0400, 32'h4000_0000, 13'h0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = 4'd0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [12:0] evt_set = 13'h0;
  logic        mgmt_wr = 1'b0;
  logic        tx_ctrl_wr = 1'b0;
  logic        tx_ctrl_stop = 1'b0;
  logic [12:0] irq;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  irq_event_ctrl u_irq_event_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
    .mgmt_wr(mgmt_wr), .tx_ctrl_wr(tx_ctrl_wr), .tx_ctrl_stop(tx_ctrl_stop),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [12:0] v);
    evt_set = v;
    @(negedge clk);
    evt_set = 13'h0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", {19'h0, irq}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rst = 1'b0;
    rdreg(A_EVT, rd);  check("R1 event", rd, 32'h0);
    rdreg(A_MASK, rd); check("R1 mask", rd, 32'h0);

    // R2 R6 table of set/mask patterns
    for (int i = 0; i < NVEC; i++) begin
      wr(A_EVT, 32'hFFFF_FFFF);
      wr(A_MASK, VEC[i][44:13]);
      pulse(VEC[i][57:45]);
      @(negedge clk);
      check("R6 line map", {19'h0, irq}, {19'h0, VEC[i][12:0]});
      rdreg(A_EVT, rd);
      check("R2 event set", rd, {VEC[i][57:45], 19'h0});
    end

    // R3 partial clear
    wr(A_EVT, 32'hFFFF_FFFF);
    pulse(13'h1FFF);
    wr(A_EVT, 32'h0800_0000);
    rdreg(A_EVT, rd); check("R3 partial clear", rd, 32'hF7F8_0000);
    // R5 low bits read zero even after writing ones there
    wr(A_EVT, 32'h0007_FFFF);
    rdreg(A_EVT, rd); check("R5 low bits", rd, 32'hF7F8_0000);

    // R4 mask read/write
    wr(A_MASK, 32'hA5A5_1234);
    rdreg(A_MASK, rd); check("R4 mask", rd, 32'hA5A5_1234);

    // R11 unmapped address reads zero; read shows pre-write value
    rdreg(4'd7, rd); check("R11 unmapped", rd, 32'h0);
    bus_addr = A_MASK; bus_wdata = 32'h0000_00FF; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    check("R11 registered read", bus_rdata, 32'hA5A5_1234);

    // R7 one-cycle lag
    wr(A_EVT, 32'hFFFF_FFFF);
    wr(A_MASK, 32'hFFFF_FFFF);
    @(negedge clk);
    pulse(13'h0010);
    check("R7 before", {31'h0, irq[6]}, 32'h0);
    @(negedge clk);
    check("R7 after", {31'h0, irq[6]}, 32'h1);
    wr(A_MASK, 32'h0);
    check("R7 mask drop before", {31'h0, irq[6]}, 32'h1);
    @(negedge clk);
    check("R7 mask drop after", {31'h0, irq[6]}, 32'h0);

    // R8 management write
    wr(A_EVT, 32'hFFFF_FFFF);
    mgmt_wr = 1'b1; @(negedge clk); mgmt_wr = 1'b0;
    rdreg(A_EVT, rd); check("R8 mgmt", rd, 32'h0080_0000);

    // R9 transmit control write
    wr(A_EVT, 32'hFFFF_FFFF);
    tx_ctrl_wr = 1'b1; tx_ctrl_stop = 1'b0; @(negedge clk); tx_ctrl_wr = 1'b0;
    rdreg(A_EVT, rd); check("R9 no stop bit", rd, 32'h0);
    tx_ctrl_wr = 1'b1; tx_ctrl_stop = 1'b1; @(negedge clk); tx_ctrl_wr = 1'b0;
    tx_ctrl_stop = 1'b0;
    rdreg(A_EVT, rd); check("R9 stop bit", rd, 32'h1000_0000);

    // R10 set and clear in the same cycle
    wr(A_EVT, 32'hFFFF_FFFF);
    evt_set = 13'h0100;
    bus_addr = A_EVT; bus_wdata = 32'h0800_0000; bus_we = 1'b1;
    @(negedge clk);
    evt_set = 13'h0; bus_we = 1'b0;
    rdreg(A_EVT, rd); check("R10 set wins", rd, 32'h0800_0000);
    wr(A_EVT, 32'h0800_0000);
    rdreg(A_EVT, rd); check("R10 later clear", rd, 32'h0);

    // R1 mid-run reset
    wr(A_MASK, 32'hFFFF_FFFF);
    pulse(13'h1FFF);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1 irq after reset", {19'h0, irq}, 32'h0);
    rdreg(A_MASK, rd); check("R1 mask after reset", rd, 32'h0);
    rdreg(A_EVT, rd);  check("R1 event after reset", rd, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule